// File: doc/BRIEF.md
# Instruction Address Match Trigger

This block is the single hardware breakpoint of a RISC-V core. It holds the trigger CSRs: select, the type-6 match control word, the match address and the info word. These are reached through a CSR read/write port that carries a debug-mode flag with each access. For each instruction offered for issue, it compares the address with the stored match address. On equality it raises either a breakpoint-exception request or a debug-entry request, in the same cycle and before that instruction executes.

The trap controller and the debug sequencer stay outside the block. They see two request lines and a trap PC, and they answer with an acknowledge. A return pulse marks the `mret`/`dret` that resumes the program. The trap PC is the matched address itself, so the saved PC points at the instruction that still has to run. After a trap is taken, the trigger is held quiet until the first instruction issued after the return. A resume at the matched address therefore does not trap again. A lock bit, settable only from debug mode, shields the trigger from machine-mode writes.

Top module: `iaddr_trigger`

## Requirements
- R1: After reset, the match control word (CSR 0x7A1) reads 0x60000048, the match address (0x7A2) reads 0, and neither request output is high.
- R2: CSR 0x7A0 always reads 0 and CSR 0x7A4 always reads 0x01000006. Writes to either have no visible effect. Any other CSR address reads 0.
- R3: In the match control word, only three fields are writable: lock (bit 27), action (bits 15:12) and execute-enable (bit 2). An action of 0001 is stored as debug entry, and any other value is stored as 0000 (exception). The fixed bits read type 6 in bits 31:28, bit 6 = 1 (machine) and bit 3 = 1 (user mode present), and zero elsewhere.
- R4: The lock bit changes only on a write made with the debug-mode flag set. A write without that flag leaves the lock bit as it was.
- R5: While the lock bit is 1, writes to 0x7A1 and 0x7A2 made without the debug-mode flag are ignored. Writes made with the flag take effect.
- R6: A match fires in the same cycle when all of these hold: an instruction is offered, execute-enable is 1, its address equals the match address, the core is not in debug mode, and the trigger is not suppressed. This applies in both machine and user mode. Action 0000 drives `brk_exc_o` and action 0001 drives `brk_dbg_o`, never both at once.
- R7: While a request is high, `trap_pc_o` equals the matched instruction address. Otherwise it is 0.
- R8: The hit flag (bit 22 of 0x7A1) reads 1 from the cycle after a fire. A write of 0 to bit 22 clears it, and a write of 1 leaves it unchanged. A fire in the same cycle as a clearing write wins.
- R9: No request is raised while the debug-mode flag is set, or while execute-enable is 0.
- R10: When `trap_ack_i` is high together with a request, matching is masked. The mask lasts until the first instruction offered after a `ret_i` pulse, and that instruction is masked too. Later matches fire again.
- R11: The match address holds a full 32-bit value written at 0x7A2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for `csr_addr_i` |
| dbg_mode_i | input | 1 | core is in debug mode |
| priv_m_i | input | 1 | 1 = machine mode, 0 = user mode |
| issue_valid_i | input | 1 | an instruction is about to execute |
| issue_pc_i | input | 32 | address of that instruction |
| trap_ack_i | input | 1 | trap controller takes the current request |
| ret_i | input | 1 | return from trap or debug retired |
| brk_exc_o | output | 1 | breakpoint exception request |
| brk_dbg_o | output | 1 | debug-mode entry request |
| trap_pc_o | output | 32 | PC to save for the trap |

## Verification
The request lines and `trap_pc_o` are combinational, so they are due in the same cycle as the issue inputs that cause them. The bench checks them a quarter period after driving, before the next edge. CSR writes, the hit flag and the suppression state take effect at the following edge. They are checked through `csr_rdata_o` and the request lines one cycle after the stimulus. The reference model advances its own state only after each rising edge, so every comparison matches that one-cycle latency.

// File: rtl/iat_pkg.sv
package iat_pkg;
  localparam logic [11:0] CSR_TSEL  = 12'h7A0;
  localparam logic [11:0] CSR_TD1   = 12'h7A1;
  localparam logic [11:0] CSR_TD2   = 12'h7A2;
  localparam logic [11:0] CSR_TINFO = 12'h7A4;
  localparam logic [3:0]  TD1_TYPE  = 4'h6;
  localparam logic [31:0] TINFO_VAL = 32'h0100_0006;

  typedef struct packed {
    logic dmode;
    logic dbg_act;
    logic exec;
    logic hit;
  } td1_state_t;
endpackage

// File: rtl/iat_regs.sv
module iat_regs
  import iat_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            dbg_mode_i,
  input  logic            fire_i,
  output td1_state_t      td1_o,
  output logic [XLEN-1:0] tdata2_o
);
  logic locked, wr_ok;
  assign locked = td1_o.dmode && !dbg_mode_i;
  assign wr_ok  = we_i && !locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      td1_o    <= '0;
      tdata2_o <= '0;
    end else begin
      if (wr_ok && addr_i == CSR_TD1) begin
        if (dbg_mode_i) td1_o.dmode <= wdata_i[27];
        td1_o.dbg_act <= (wdata_i[15:12] == 4'b0001);
        td1_o.exec    <= wdata_i[2];
        td1_o.hit     <= fire_i | (td1_o.hit & wdata_i[22]);
      end else begin
        td1_o.hit <= td1_o.hit | fire_i;
      end
      if (wr_ok && addr_i == CSR_TD2) tdata2_o <= wdata_i;
    end
  end
endmodule

// File: rtl/iat_match.sv
module iat_match #(
  parameter int XLEN  = 32,
  parameter bit HAS_U = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_valid_i,
  input  logic [XLEN-1:0] issue_pc_i,
  input  logic [XLEN-1:0] tdata2_i,
  input  logic            exec_i,
  input  logic            dbg_act_i,
  input  logic            dbg_mode_i,
  input  logic            priv_m_i,
  input  logic            ack_i,
  input  logic            ret_i,
  output logic            fire_o,
  output logic            fire_exc_o,
  output logic            fire_dbg_o,
  output logic [XLEN-1:0] trap_pc_o
);
  logic skip_q, ret_seen_q, priv_ok;

  generate
    if (HAS_U) begin : g_user
      assign priv_ok = 1'b1;
    end else begin : g_monly
      assign priv_ok = priv_m_i;
    end
  endgenerate

  assign fire_o = issue_valid_i && exec_i && !dbg_mode_i && priv_ok && !skip_q
                  && (issue_pc_i == tdata2_i);
  assign fire_exc_o = fire_o && !dbg_act_i;
  assign fire_dbg_o = fire_o &&  dbg_act_i;
  assign trap_pc_o  = fire_o ? issue_pc_i : '0;

  // mask from trap acceptance to first issue after return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q     <= 1'b0;
      ret_seen_q <= 1'b0;
    end else if (fire_o && ack_i) begin
      skip_q     <= 1'b1;
      ret_seen_q <= 1'b0;
    end else if (skip_q && ret_seen_q && issue_valid_i) begin
      skip_q     <= 1'b0;
      ret_seen_q <= 1'b0;
    end else if (skip_q && ret_i) begin
      ret_seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/iaddr_trigger.sv
module iaddr_trigger
  import iat_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter bit HAS_U = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [31:0]     csr_wdata_i,
  output logic [31:0]     csr_rdata_o,
  input  logic            dbg_mode_i,
  input  logic            priv_m_i,
  input  logic            issue_valid_i,
  input  logic [31:0]     issue_pc_i,
  input  logic            trap_ack_i,
  input  logic            ret_i,
  output logic            brk_exc_o,
  output logic            brk_dbg_o,
  output logic [31:0]     trap_pc_o
);
  td1_state_t      td1;
  logic [XLEN-1:0] tdata2_q;
  logic            fire;
  logic            hit_w, dmode_w;
  logic [31:0]     td1_rd;

  assign hit_w   = td1.hit;
  assign dmode_w = td1.dmode;

  iat_regs #(.XLEN(XLEN)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(csr_we_i), .addr_i(csr_addr_i),
    .wdata_i(csr_wdata_i), .dbg_mode_i(dbg_mode_i), .fire_i(fire),
    .td1_o(td1), .tdata2_o(tdata2_q)
  );

  iat_match #(.XLEN(XLEN), .HAS_U(HAS_U)) u_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i),
    .issue_pc_i(issue_pc_i), .tdata2_i(tdata2_q), .exec_i(td1.exec),
    .dbg_act_i(td1.dbg_act), .dbg_mode_i(dbg_mode_i), .priv_m_i(priv_m_i),
    .ack_i(trap_ack_i), .ret_i(ret_i), .fire_o(fire),
    .fire_exc_o(brk_exc_o), .fire_dbg_o(brk_dbg_o), .trap_pc_o(trap_pc_o)
  );

  always_comb begin
    td1_rd        = '0;
    td1_rd[31:28] = TD1_TYPE;
    td1_rd[27]    = td1.dmode;
    td1_rd[22]    = td1.hit;
    td1_rd[12]    = td1.dbg_act;
    td1_rd[6]     = 1'b1;
    td1_rd[3]     = HAS_U;
    td1_rd[2]     = td1.exec;
  end

  always_comb begin
    unique case (csr_addr_i)
      CSR_TD1:   csr_rdata_o = td1_rd;
      CSR_TD2:   csr_rdata_o = tdata2_q;
      CSR_TINFO: csr_rdata_o = TINFO_VAL;
      default:   csr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/iat_chk.sv
module iat_chk
  import iat_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dbg_mode_i,
  input logic        csr_we_i,
  input logic [11:0] csr_addr_i,
  input logic [31:0] issue_pc_i,
  input logic        trap_ack_i,
  input logic        brk_exc_o,
  input logic        brk_dbg_o,
  input logic [31:0] trap_pc_o,
  input logic [31:0] tdata2,
  input logic        hit,
  input logic        dmode
);
  logic any_fire;
  assign any_fire = brk_exc_o || brk_dbg_o;

  // R6
  excl_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(brk_exc_o && brk_dbg_o));
  // R9
  no_fire_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_mode_i |-> !any_fire);
  // R7
  trap_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_fire |-> (trap_pc_o == tdata2) && (issue_pc_i == tdata2));
  // R8
  hit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_fire |=> hit);
  // R5
  lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmode && !dbg_mode_i && csr_we_i && csr_addr_i == CSR_TD2) |=> $stable(tdata2));
  // R10
  skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_fire && trap_ack_i) |=> !any_fire);
endmodule

bind iaddr_trigger iat_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dbg_mode_i(dbg_mode_i), .csr_we_i(csr_we_i),
  .csr_addr_i(csr_addr_i), .issue_pc_i(issue_pc_i), .trap_ack_i(trap_ack_i),
  .brk_exc_o(brk_exc_o), .brk_dbg_o(brk_dbg_o), .trap_pc_o(trap_pc_o),
  .tdata2(tdata2_q), .hit(hit_w), .dmode(dmode_w)
);

// File: tb/sim_iaddr_trigger.sv
module sim_iaddr_trigger;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        csr_we = 0, dbg = 0, pm = 1, iv = 0, ack = 0, ret = 0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0, pc = '0;
  logic [31:0] rdata, tpc;
  logic        bexc, bdbg;
  int          errs = 0, checks = 0;

  // reference state
  bit          m_dmode, m_act, m_exec, m_hit, m_skip, m_ret;
  logic [31:0] m_t2;

  always #(CLK_PERIOD/2) clk = ~clk;

  iaddr_trigger u0 (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(csr_we), .csr_addr_i(addr),
    .csr_wdata_i(wd), .csr_rdata_o(rdata), .dbg_mode_i(dbg), .priv_m_i(pm),
    .issue_valid_i(iv), .issue_pc_i(pc), .trap_ack_i(ack), .ret_i(ret),
    .brk_exc_o(bexc), .brk_dbg_o(bdbg), .trap_pc_o(tpc)
  );

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] t1;
    t1 = 32'h6000_0048 | (32'(m_dmode) << 27) | (32'(m_hit) << 22)
       | (32'(m_act) << 12) | (32'(m_exec) << 2);
    case (a)
      12'h7A1: return t1;
      12'h7A2: return m_t2;
      12'h7A4: return 32'h0100_0006;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit w, logic [11:0] a, logic [31:0] d, bit dm, bit pmi,
                      bit ivi, logic [31:0] pci, bit acki, bit reti);
    bit f;
    @(negedge clk);
    csr_we = w; addr = a; wd = d; dbg = dm; pm = pmi; iv = ivi; pc = pci; ack = acki; ret = reti;
    #(CLK_PERIOD/4);
    f = ivi && m_exec && !dm && !m_skip && (pci == m_t2);
    chk(tag, "rdata", rdata, exp_rd(a));
    chk(tag, "brk_exc", 32'(bexc), 32'(f && !m_act));
    chk(tag, "brk_dbg", 32'(bdbg), 32'(f && m_act));
    chk(tag, "trap_pc", tpc, f ? pci : 32'h0);
    @(posedge clk);
    #1;
    if (w && !(m_dmode && !dm)) begin
      if (a == 12'h7A1) begin
        if (dm) m_dmode = d[27];
        m_act  = (d[15:12] == 4'b0001);
        m_exec = d[2];
        m_hit  = m_hit & d[22];
      end
      if (a == 12'h7A2) m_t2 = d;
    end
    if (f) m_hit = 1;
    if (f && acki) begin m_skip = 1; m_ret = 0; end
    else if (m_skip && m_ret && ivi) begin m_skip = 0; m_ret = 0; end
    else if (m_skip && reti) m_ret = 1;
  endtask

  task automatic wr(string tag, bit dm, logic [11:0] a, logic [31:0] d);
    step(tag, 1, a, d, dm, 1, 0, 32'h0, 0, 0);
  endtask
  task automatic rd(string tag, logic [11:0] a);
    step(tag, 0, a, 32'h0, 0, 1, 0, 32'h0, 0, 0);
  endtask
  task automatic iss(string tag, logic [31:0] p, bit pmi, bit dm, bit acki, bit reti);
    step(tag, 0, 12'h7A1, 32'h0, dm, pmi, 1, p, acki, reti);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    localparam logic [31:0] BP = 32'h8000_0100;
    m_dmode = 0; m_act = 0; m_exec = 0; m_hit = 0; m_skip = 0; m_ret = 0; m_t2 = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset values
    rd("R1", 12'h7A1);
    rd("R1", 12'h7A2);
    // R2 fixed registers
    wr("R2", 1, 12'h7A0, 32'hFFFF_FFFF);
    rd("R2", 12'h7A0);
    wr("R2", 1, 12'h7A4, 32'h0);
    rd("R2", 12'h7A4);
    rd("R2", 12'h7A3);
    // R11 full-width address
    wr("R11", 0, 12'h7A2, 32'hA5C3_0F1E);
    rd("R11", 12'h7A2);
    wr("R11", 0, 12'h7A2, BP);
    // R3 only writable fields land; action 0, execute 1, lock ignored in M-mode (R4)
    wr("R3", 0, 12'h7A1, 32'hFFFF_0FFF);
    rd("R4", 12'h7A1);
    // R6 R7 exception request, no ack
    iss("R6", BP, 1, 0, 0, 0);
    rd("R8", 12'h7A1);
    iss("R6", BP + 4, 1, 0, 0, 0);
    // R10 acked fire masks until issue after return
    iss("R10", BP, 1, 0, 1, 0);
    iss("R10", BP, 1, 0, 0, 0);
    iss("R10", BP, 1, 0, 0, 1);
    iss("R10", BP, 1, 0, 0, 0);
    iss("R10", BP, 1, 0, 0, 0);
    // R8 hit cleared only by zero write
    wr("R8", 0, 12'h7A1, 32'h0040_0004);
    rd("R8", 12'h7A1);
    wr("R8", 0, 12'h7A1, 32'h0000_0004);
    rd("R8", 12'h7A1);
    // R3 action 0001 -> debug request, user mode (R6)
    wr("R3", 0, 12'h7A1, 32'h0000_1004);
    rd("R3", 12'h7A1);
    iss("R6", BP, 0, 0, 0, 0);
    // R9 debug mode blocks
    iss("R9", BP, 1, 1, 0, 0);
    // R3 illegal action stored as 0
    wr("R3", 0, 12'h7A1, 32'h0000_5004);
    rd("R3", 12'h7A1);
    iss("R3", BP, 1, 0, 0, 0);
    // R9 execute disabled
    wr("R9", 0, 12'h7A1, 32'h0000_0000);
    iss("R9", BP, 1, 0, 0, 0);
    // R4 lock set from debug mode
    wr("R4", 1, 12'h7A1, 32'h0800_0004);
    rd("R4", 12'h7A1);
    // R5 machine writes ignored while locked
    wr("R5", 0, 12'h7A2, 32'h1234_5678);
    rd("R5", 12'h7A2);
    wr("R5", 0, 12'h7A1, 32'h0000_0000);
    rd("R5", 12'h7A1);
    iss("R5", BP, 1, 0, 0, 0);
    // R5 debug writes still work; R4 lock cleared from debug
    wr("R5", 1, 12'h7A2, 32'h0000_2000);
    rd("R5", 12'h7A2);
    wr("R4", 1, 12'h7A1, 32'h0000_0004);
    rd("R4", 12'h7A1);
    iss("R6", 32'h0000_2000, 1, 0, 0, 0);
    // R8 fire wins over clearing write in same cycle
    step("R8", 1, 12'h7A1, 32'h0000_0004, 0, 1, 1, 32'h0000_2000, 0, 0);
    rd("R8", 12'h7A1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule